// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Codes

This block is the multi-cycle divide unit of a CPU execution stage. A one-cycle `start` captures the operands, the width mode and the signedness. The block then runs a radix-2 restoring division on magnitudes for a fixed number of cycles. It corrects the signs at the end and decides on overflow. It then pulses `done` together with register write enables and the N/Z/V/C condition codes.

Three widths are supported:

- **Word:** a 32-bit dividend and a 16-bit divisor. Remainder and quotient are packed into a single destination word.
- **Long:** a 32-bit dividend and a 32-bit divisor.
- **Quad:** a 64-bit dividend built from a high and a low register, with a 32-bit divisor.

A zero divisor raises a trap instead of writing a result. An out-of-range quotient sets V and suppresses all writes. The register file and the trap sequencing are outside the block. The surrounding stage supplies the current N flag, because overflow must leave N unchanged. It also supplies a flag that says whether the quotient and remainder destinations are the same register.

Top module: `seq_divider`

## Requirements
- R1: Mode code 0 (word) divides `dvd_lo` by `divisor[15:0]`. The result word on `quot_out` carries the remainder in bits 31:16 and the quotient in bits 15:0. Only `quot_we` is raised.
- R2: Mode codes 1 and 3 (long) divide `dvd_lo` by `divisor` and never overflow; the quotient is on `quot_out` and the remainder on `rem_out`. In long and quad modes `rem_we` is raised only when `same_reg` is 0, so the quotient alone is written when both destinations coincide.
- R3: Mode code 2 (quad) uses the 64-bit dividend `{dvd_hi, dvd_lo}`, with `dvd_hi` as the upper half.
- R4: With `is_signed` = 1, operands are two's complement. In word and long modes `dvd_lo` is sign extended. In word mode `divisor[15:0]` is sign extended. The quotient truncates toward zero and the remainder takes the sign of the dividend.
- R5: A zero divisor raises `dz_trap` with `done`. It writes nothing, sets N to `n_prev` and clears Z and V. In word mode only `divisor[15:0]` is tested for zero.
- R6: A quotient that does not fit in 16 bits (word mode) or 32 bits (quad mode) is an overflow. The range is unsigned or signed as selected. On overflow V = 1, Z = 0, N = `n_prev`, and no write enable is raised.
- R7: Without overflow or trap, N is the top bit of the quotient at the result width (bit 15 in word mode, bit 31 otherwise). Z is set when that quotient is zero, and V = 0.
- R8: C is 0 at all times, overflow included.
- R9: `done` is a single-cycle pulse. It is visible after the 66th rising edge, counting the edge that samples `start` as the first. The write enables and `dz_trap` are only high while `done` is high.
- R10: `start` is ignored from the accepting edge until `done` is raised. A second request neither changes the running result nor produces a second `done`.
- R11: After reset, `done`, `quot_we`, `rem_we`, `dz_trap` and the flags N, Z, V are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only when idle |
| mode | input | 2 | 0 word, 1 or 3 long, 2 quad |
| is_signed | input | 1 | 1 selects two's-complement operands |
| dvd_hi | input | 32 | Upper dividend half (quad mode only) |
| dvd_lo | input | 32 | Lower dividend half, or whole dividend |
| divisor | input | 32 | Divisor (low 16 bits in word mode) |
| same_reg | input | 1 | Quotient and remainder destinations coincide |
| n_prev | input | 1 | Current N flag, kept on overflow or trap |
| quot_out | output | 32 | Quotient, or packed remainder:quotient in word mode |
| rem_out | output | 32 | Remainder |
| quot_we | output | 1 | Write `quot_out` to the quotient register |
| rem_we | output | 1 | Write `rem_out` to the remainder register |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry, always 0 |
| dz_trap | output | 1 | Divide-by-zero trap request |
| done | output | 1 | Result and flags valid this cycle |

## Verification
The hardest case to reach from the ports is a start request that arrives while a division is in flight. It must not disturb the running operands or the latency. The bench raises a second `start` with different operands ten cycles into a run. It checks that the first result appears at the nominal cycle and that no further `done` follows. The signed range edges are also deliberately targeted:
- a word-mode quotient of exactly -32768 (fits) against +32768 (overflows);
- a word-mode divisor whose low half is zero while its upper bits are not, which must still trap.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic         is_signed,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  input  logic         same_reg,
  input  logic         n_prev,
  output logic [W-1:0] quot_out,
  output logic [W-1:0] rem_out,
  output logic         quot_we,
  output logic         rem_we,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c,
  output logic         dz_trap,
  output logic         done
);
  localparam int HW  = W / 2;
  localparam int DW  = 2 * W;
  localparam int LAT = DW + 1;
  localparam int CW  = $clog2(DW + 2);
  localparam logic [1:0] MD_WORD = 2'd0;
  localparam logic [1:0] MD_QUAD = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ITER, S_FIN} st_t;

  st_t            st;
  logic [CW-1:0]  cnt, lat_cnt;
  logic [W-1:0]   rem_r, dvs_r;
  logic [DW-1:0]  q_r;
  logic [1:0]     mode_r;
  logic           sgn_r, neg_q_r, neg_r_r, same_r, nprev_r, dz_r;

  // operand preparation at start
  logic           w_in, q_in;
  logic [W-1:0]   dvs_ext, dvs_mag;
  logic [DW-1:0]  dvd_ext, dvd_mag;
  logic           dvd_neg, dvs_neg;

  assign w_in    = (mode == MD_WORD);
  assign q_in    = (mode == MD_QUAD);
  assign dvs_ext = w_in ? {{HW{is_signed & divisor[HW-1]}}, divisor[HW-1:0]} : divisor;
  assign dvd_ext = q_in ? {dvd_hi, dvd_lo} : {{W{is_signed & dvd_lo[W-1]}}, dvd_lo};
  assign dvd_neg = is_signed & dvd_ext[DW-1];
  assign dvs_neg = is_signed & dvs_ext[W-1];
  assign dvd_mag = dvd_neg ? -dvd_ext : dvd_ext;
  assign dvs_mag = dvs_neg ? -dvs_ext : dvs_ext;

  // one restoring step
  logic [W:0] trial, diff;
  logic       ge;

  assign trial = {rem_r, q_r[DW-1]};
  assign diff  = trial - {1'b0, dvs_r};
  assign ge    = ~diff[W];

  // sign correction and range test
  logic [DW-1:0] q_s;
  logic [W-1:0]  r_s;
  logic          w_md_r, ovf_w, ovf_q, ovf;

  assign w_md_r = (mode_r == MD_WORD);
  assign q_s    = neg_q_r ? -q_r : q_r;
  assign r_s    = neg_r_r ? -rem_r : rem_r;
  assign ovf_w  = sgn_r ? ~((&q_s[DW-1:HW-1]) | ~(|q_s[DW-1:HW-1])) : (|q_r[DW-1:HW]);
  assign ovf_q  = sgn_r ? ~((&q_s[DW-1:W-1]) | ~(|q_s[DW-1:W-1])) : (|q_r[DW-1:W]);
  assign ovf    = w_md_r ? ovf_w : ((mode_r == MD_QUAD) ? ovf_q : 1'b0);
  assign flag_c = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rem_r    <= '0;
      dvs_r    <= '0;
      q_r      <= '0;
      mode_r   <= '0;
      sgn_r    <= 1'b0;
      neg_q_r  <= 1'b0;
      neg_r_r  <= 1'b0;
      same_r   <= 1'b0;
      nprev_r  <= 1'b0;
      dz_r     <= 1'b0;
      quot_out <= '0;
      rem_out  <= '0;
      quot_we  <= 1'b0;
      rem_we   <= 1'b0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      flag_v   <= 1'b0;
      dz_trap  <= 1'b0;
      done     <= 1'b0;
    end else begin
      quot_we <= 1'b0;
      rem_we  <= 1'b0;
      dz_trap <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st      <= S_ITER;
          cnt     <= '0;
          rem_r   <= '0;
          q_r     <= dvd_mag;
          dvs_r   <= dvs_mag;
          mode_r  <= mode;
          sgn_r   <= is_signed;
          neg_q_r <= dvd_neg ^ dvs_neg;
          neg_r_r <= dvd_neg;
          same_r  <= same_reg;
          nprev_r <= n_prev;
          dz_r    <= (dvs_ext == '0);
        end
        S_ITER: begin
          rem_r <= ge ? diff[W-1:0] : trial[W-1:0];
          q_r   <= {q_r[DW-2:0], ge};
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(DW - 1)) st <= S_FIN;
        end
        S_FIN: begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (dz_r) begin
            dz_trap <= 1'b1;
            flag_n  <= nprev_r;
            flag_z  <= 1'b0;
            flag_v  <= 1'b0;
          end else if (ovf) begin
            flag_n <= nprev_r;
            flag_z <= 1'b0;
            flag_v <= 1'b1;
          end else begin
            quot_we  <= 1'b1;
            rem_we   <= ~w_md_r & ~same_r;
            quot_out <= w_md_r ? {r_s[HW-1:0], q_s[HW-1:0]} : q_s[W-1:0];
            rem_out  <= r_s;
            flag_n   <= w_md_r ? q_s[HW-1] : q_s[W-1];
            flag_z   <= w_md_r ? (q_s[HW-1:0] == '0) : (q_s[W-1:0] == '0);
            flag_v   <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // cycles since the accepted start, kept apart from the sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_cnt <= '0;
    else if (st == S_IDLE && start) lat_cnt <= '0;
    else if (st != S_IDLE)          lat_cnt <= lat_cnt + 1'b1;
  end

  a_r5_dz_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dz_trap) |-> (!quot_we && !rem_we && !flag_v && flag_n == nprev_r));

  a_r6_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_v) |-> (!quot_we && !rem_we && !flag_z && flag_n == nprev_r));

  a_r2_same_reg: assert property (@(posedge clk) disable iff (!rst_n)
    rem_we |-> (quot_we && !same_r && mode_r != MD_WORD));

  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (quot_we || rem_we || dz_trap) |-> done);

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == CW'(LAT)));

  a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ITER && start) |=> (lat_cnt == $past(lat_cnt) + 1'b1));
endmodule

// File: tb/seq_divider_tb_top.sv
`timescale 1ns/1ps
module seq_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic        is_signed = 1'b0;
  logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic        same_reg = 1'b0, n_prev = 1'b0;
  logic [31:0] quot_out, rem_out;
  logic        quot_we, rem_we, flag_n, flag_z, flag_v, flag_c, dz_trap, done;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  seq_divider dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_signed(is_signed),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor), .same_reg(same_reg),
    .n_prev(n_prev), .quot_out(quot_out), .rem_out(rem_out), .quot_we(quot_we),
    .rem_we(rem_we), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .dz_trap(dz_trap), .done(done));

  typedef struct packed {
    logic dz, ovf, qwe, rwe, n, z, v;
    logic [31:0] qd, rd;
  } exp_t;

  // {mode, signed, same, hi, lo, divisor}
  localparam logic [99:0] VEC [16] = '{
    {2'd0, 1'b0, 1'b0, 32'h0,        32'd100000,   32'd7},
    {2'd0, 1'b0, 1'b0, 32'h0,        32'h0010_0000, 32'd1},
    {2'd0, 1'b1, 1'b0, 32'h0,        32'hFFFF_FFF9, 32'h0000_0002},
    {2'd0, 1'b1, 1'b0, 32'h0,        32'h0000_8000, 32'd1},
    {2'd0, 1'b1, 1'b0, 32'h0,        32'hFFFF_8000, 32'd1},
    {2'd1, 1'b0, 1'b0, 32'h0,        32'hFFFF_FFFF, 32'd3},
    {2'd1, 1'b1, 1'b0, 32'h0,        32'hFFFF_FF9C, 32'd7},
    {2'd3, 1'b0, 1'b1, 32'h0,        32'd100,       32'd7},
    {2'd2, 1'b0, 1'b0, 32'h1,        32'h0,         32'd2},
    {2'd2, 1'b0, 1'b0, 32'h2,        32'h0,         32'd2},
    {2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FFFD},
    {2'd2, 1'b1, 1'b1, 32'h4000_0000, 32'h0,        32'd1},
    {2'd1, 1'b1, 1'b0, 32'h0,        32'd3,         32'd7},
    {2'd0, 1'b0, 1'b0, 32'h0,        32'd55,        32'h0001_0000},
    {2'd1, 1'b1, 1'b0, 32'h0,        32'd55,        32'h0},
    {2'd2, 1'b0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1357_9BDF}
  };

  function automatic exp_t model(input logic [1:0] md, input logic sg, input logic sm,
                                 input logic [31:0] hi, input logic [31:0] lo,
                                 input logic [31:0] dv, input logic np);
    exp_t e;
    logic [63:0] d64;
    logic [31:0] v32;
    logic signed [127:0] a, b, q, r;
    logic fit;
    e = '0;
    d64 = (md == 2'd2) ? {hi, lo} : (sg ? {{32{lo[31]}}, lo} : {32'h0, lo});
    v32 = (md == 2'd0) ? (sg ? {{16{dv[15]}}, dv[15:0]} : {16'h0, dv[15:0]}) : dv;
    a = sg ? {{64{d64[63]}}, d64} : {64'h0, d64};
    b = sg ? {{96{v32[31]}}, v32} : {96'h0, v32};
    if (b == 0) begin
      e.dz = 1'b1; e.n = np;
      return e;
    end
    q = a / b;
    r = a % b;
    if (md == 2'd0)
      fit = sg ? (q >= -128'sd32768 && q <= 128'sd32767) : (q <= 128'sd65535);
    else if (md == 2'd2)
      fit = sg ? (q >= -128'sd2147483648 && q <= 128'sd2147483647) : (q <= 128'sd4294967295);
    else
      fit = 1'b1;
    if (!fit) begin
      e.ovf = 1'b1; e.v = 1'b1; e.n = np; e.z = 1'b0;
      return e;
    end
    e.qwe = 1'b1;
    if (md == 2'd0) begin
      e.qd = {r[15:0], q[15:0]};
      e.n  = q[15];
      e.z  = (q[15:0] == 16'h0);
    end else begin
      e.qd  = q[31:0];
      e.rd  = r[31:0];
      e.rwe = ~sm;
      e.n   = q[31];
      e.z   = (q[31:0] == 32'h0);
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 300);
  endtask

  task automatic run_vec(input logic [99:0] v, input logic np);
    exp_t e;
    int lat;
    string tg;
    @(negedge clk);
    {mode, is_signed, same_reg, dvd_hi, dvd_lo, divisor} = v;
    n_prev = np;
    start  = 1'b1;
    e = model(v[99:98], v[97], v[96], v[95:64], v[63:32], v[31:0], np);
    tg = v[97] ? "R4" : (v[99:98] == 2'd0 ? "R1" : (v[99:98] == 2'd2 ? "R3" : "R2"));
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk("R9", "latency", 64'(lat), 64'd66);
    chk("R8", "flag_c", 64'(flag_c), 64'd0);
    if (e.dz) begin
      chk("R5", "dz_trap", 64'(dz_trap), 64'd1);
      chk("R5", "writes", {62'd0, quot_we, rem_we}, 64'd0);
      chk("R5", "flags nzv", {61'd0, flag_n, flag_z, flag_v}, {61'd0, e.n, 2'b00});
    end else if (e.ovf) begin
      chk("R6", "writes", {62'd0, quot_we, rem_we}, 64'd0);
      chk("R6", "flags nzv", {61'd0, flag_n, flag_z, flag_v}, {61'd0, e.n, 2'b01});
      chk("R6", "dz_trap", 64'(dz_trap), 64'd0);
    end else begin
      chk(tg, "quot_out", 64'(quot_out), 64'(e.qd));
      chk(tg, "quot_we", 64'(quot_we), 64'd1);
      chk("R2", "rem_we", 64'(rem_we), 64'(e.rwe));
      if (e.rwe) chk(tg, "rem_out", 64'(rem_out), 64'(e.rd));
      chk("R7", "flags nzv", {61'd0, flag_n, flag_z, flag_v}, {61'd0, e.n, e.z, 1'b0});
    end
    @(negedge clk);
    chk("R9", "done pulse width", {61'd0, done, quot_we, dz_trap}, 64'd0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    int lat;
    int extra;
    repeat (3) @(negedge clk);
    chk("R11", "reset outputs", {58'd0, done, quot_we, rem_we, dz_trap, flag_n, flag_z},
        64'd0);
    chk("R11", "reset flag_v", 64'(flag_v), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) run_vec(VEC[i], i[0]);

    // R10: second start during a run is ignored
    @(negedge clk);
    mode = 2'd1; is_signed = 1'b0; same_reg = 1'b0;
    dvd_lo = 32'd100; divisor = 32'd7; n_prev = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    dvd_lo = 32'd50; divisor = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 12;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk("R10", "latency with ignored start", 64'(lat), 64'd66);
    chk("R10", "quotient of first request", 64'(quot_out), 64'd14);
    chk("R10", "remainder of first request", 64'(rem_out), 64'd2);
    extra = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10", "no second done", 64'(extra), 64'd0);

    // R1: packed word result with negative remainder signed
    run_vec({2'd0, 1'b1, 1'b1, 32'h0, 32'hFFFF_FF9C, 32'h0000_0007}, 1'b1);

    wait_done(lat);
    chk("R9", "no spurious done when idle", 64'(done), 64'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule